// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block stands between a queue of already-scheduled DRAM commands and the DDR command bus. In every DRAM clock cycle it looks only at the command at the head of the queue. It decides whether that command can go out without breaking a timing rule of the memory part. When it can, the block accepts the command and drives it onto the bus at the next rising clock edge. When it cannot, the head command waits, and every command behind it waits too, so the order of the queue is kept.

The block keeps one saturating down counter for each timing rule. A rule that concerns one bank has one counter per bank. Issuing a command reloads the counters that this command starts, using values from a timing table. A relevance mask, selected by command type, picks the counters that can hold the head back. Both the timing table and the mask table are written through a simple configuration port at boot, before any command is sent, so the same block can serve different DDR parts. A sleep command puts nothing on the bus. It keeps the bus idle for the number of cycles given in its operand.

The command input is valid/ready. The upstream queue presents the head on `cmd_type`, `cmd_bank` and `cmd_arg` with `cmd_valid`, and must hold these values stable until it sees `cmd_valid && cmd_ready` at a rising edge. `cmd_ready` is computed from the presented type and bank only, and never from `cmd_valid`. The bus side has no back-pressure: a command that has been accepted is always driven.

Top module: `dram_tc_checker`

## Requirements
- R1: After reset, the bus shows nothing (`bus_valid`=0), every counter is zero, and every timing value and mask is zero. A head command is then ready at once.
- R2: A command is accepted only on a rising edge with `cmd_valid && cmd_ready`. In the cycle that follows, `bus_valid`=1 and `bus_type`/`bus_bank`/`bus_arg` carry that command. If no command was accepted, `bus_valid`=0 in the next cycle.
- R3: When `cfg_we`=1 and `cfg_addr[4]`=0, the value in `cfg_data[7:0]` is written as the timing value for constraint `cfg_addr[3:0]`. Constraint indices are: 0 tRCD, 1 tRP, 2 tRAS, 3 tRTP, 4 tCCD, 5 tWTR, 6 tCAS, 7 tRFC, 8 tXP. When `cfg_addr[4]`=1, `cfg_data[8:0]` is written as the relevance mask of command type `cfg_addr[3:0]`, and mask bit i stands for constraint i.
- R4: A counter whose mask bit is clear for the head's type never stalls that head. For example, a running tCAS counter does not hold back a precharge whose mask leaves bit 6 clear.
- R5: While any counter that the mask marks as relevant is nonzero, `cmd_ready`=0, the head is not accepted and `bus_valid` stays 0.
- R6: A counter started with timing value N makes the next command that depends on it wait until at least N cycles after the starting command was accepted. When nothing else is in the way, the wait is exactly N cycles. Values 0 and 1 both allow back-to-back issue. Counters count down to zero and stay there.
- R7: tRCD, tRP, tRAS and tRTP are kept per bank and are checked against the head's `cmd_bank`. A counter running in one bank does not stall a command to another bank.
- R8: Command type codes are: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 power-down, 7 power-up, 8 sleep. Issuing a command starts these counters:
  - activate starts tRCD and tRAS in its bank;
  - read starts tCCD, tCAS, and tRTP in its bank;
  - write starts tCCD and tWTR;
  - precharge starts tRP in its bank;
  - refresh starts tRFC;
  - power-up starts tXP;
  - the other types start nothing.
- R9: An accepted sleep command with operand N does not appear on the bus (`bus_valid`=0). It keeps every type of next command out until N cycles after the sleep was accepted; operand 0 or 1 blocks nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Bit 4 selects the mask table, bits 3:0 give the index |
| cfg_data | input | 9 | Timing value (bits 7:0) or relevance mask (bits 8:0) |
| cmd_valid | input | 1 | A head command is present |
| cmd_ready | output | 1 | The presented head satisfies every relevant constraint |
| cmd_type | input | 4 | Head command type code |
| cmd_bank | input | 3 | Head command bank |
| cmd_arg | input | 8 | Head operand (sleep length, or passed through to the bus) |
| bus_valid | output | 1 | A command is on the bus this cycle |
| bus_type | output | 4 | Type of the command on the bus |
| bus_bank | output | 3 | Bank of the command on the bus |
| bus_arg | output | 8 | Operand of the command on the bus |

## Verification
The most delicate case is a cycle in which one counter reaches zero and, in the same cycle, an accepted command reloads that same counter. This happens when a read is accepted on the exact cycle its tCCD window closes, and the read then restarts tCCD for the next read. A later case has a precharge accepted while a tCAS count that it ignores is still running. The stimulus sequence places back-to-back commands so that these collisions land on known cycles. The bench then checks the number of cycles between acceptances against values worked out by hand from the configured timings, and checks that the bus shows exactly the accepted command one cycle later.

// File: rtl/dram_tc_pkg.sv
package dram_tc_pkg;

  localparam int NUM_CON   = 9;  // timing constraints tracked
  localparam int NUM_BANKC = 4;  // leading constraints that are bank-scoped
  localparam int TYPE_W    = 4;
  localparam int NUM_TYPES = 2 ** TYPE_W;

  // constraint indices; bank-scoped ones come first
  localparam int C_RCD = 0;
  localparam int C_RP  = 1;
  localparam int C_RAS = 2;
  localparam int C_RTP = 3;
  localparam int C_CCD = 4;
  localparam int C_WTR = 5;
  localparam int C_CAS = 6;
  localparam int C_RFC = 7;
  localparam int C_XP  = 8;

  typedef enum logic [TYPE_W-1:0] {
    CMD_NOP = 4'd0,
    CMD_ACT = 4'd1,
    CMD_RD  = 4'd2,
    CMD_WR  = 4'd3,
    CMD_PRE = 4'd4,
    CMD_REF = 4'd5,
    CMD_PDN = 4'd6,
    CMD_PUP = 4'd7,
    CMD_SLP = 4'd8
  } cmd_e;

  // R8: counters restarted when a command of type t issues
  function automatic logic [NUM_CON-1:0] start_set(input logic [TYPE_W-1:0] t);
    logic [NUM_CON-1:0] s;
    s = '0;
    case (t)
      CMD_ACT: begin s[C_RCD] = 1'b1; s[C_RAS] = 1'b1; end
      CMD_RD:  begin s[C_CCD] = 1'b1; s[C_CAS] = 1'b1; s[C_RTP] = 1'b1; end
      CMD_WR:  begin s[C_CCD] = 1'b1; s[C_WTR] = 1'b1; end
      CMD_PRE: s[C_RP]  = 1'b1;
      CMD_REF: s[C_RFC] = 1'b1;
      CMD_PUP: s[C_XP]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dram_tc_counter.sv
module dram_tc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         nz
);

  logic [W-1:0] cnt;

  // loading N-1 lets a dependent command go exactly N cycles later
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= (val == '0) ? '0 : val - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign nz = (cnt != '0);

  // R6: an idle counter at zero stays at zero
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));

  // R6: a running counter steps down by one
  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dram_tc_cfg.sv
module dram_tc_cfg
  import dram_tc_pkg::*;
#(
  parameter int TW     = 8,
  parameter int CFG_AW = 5,
  parameter int CFG_DW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_data,
  input  logic [TYPE_W-1:0]     sel_type,
  output logic [NUM_CON-1:0]    sel_mask,
  output logic [NUM_CON*TW-1:0] tval_flat
);

  logic [TW-1:0]      tval [NUM_CON];
  logic [NUM_CON-1:0] mask [NUM_TYPES];

  wire              to_mask = cfg_addr[CFG_AW-1];
  wire [TYPE_W-1:0] idx     = cfg_addr[TYPE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CON; i++)   tval[i] <= '0;
      for (int i = 0; i < NUM_TYPES; i++) mask[i] <= '0;
    end else if (cfg_we) begin
      if (to_mask)
        mask[idx] <= cfg_data[NUM_CON-1:0];
      else if (idx < TYPE_W'(NUM_CON))
        tval[idx] <= cfg_data[TW-1:0];
    end
  end

  assign sel_mask = mask[sel_type];

  always_comb begin
    for (int i = 0; i < NUM_CON; i++) tval_flat[i*TW +: TW] = tval[i];
  end

endmodule

// File: rtl/dram_tc_timers.sv
module dram_tc_timers
  import dram_tc_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int TW    = 8,
  parameter int ARG_W = 8,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue,
  input  logic [BANK_W-1:0]     issue_bank,
  input  logic [NUM_CON-1:0]    start_vec,
  input  logic [NUM_CON*TW-1:0] tval_flat,
  input  logic                  sleep_load,
  input  logic [ARG_W-1:0]      sleep_len,
  input  logic [BANK_W-1:0]     head_bank,
  output logic [NUM_CON-1:0]    busy,
  output logic                  sleep_busy
);

  logic [NUM_BANKC*NBANK-1:0] bank_nz;
  logic [NUM_CON-1:0]         glob_nz;

  for (genvar c = 0; c < NUM_CON; c++) begin : g_con
    if (c < NUM_BANKC) begin : g_banked
      for (genvar b = 0; b < NBANK; b++) begin : g_b
        dram_tc_counter #(.W(TW)) u_cnt (
          .clk  (clk),
          .rst_n(rst_n),
          .load (issue && start_vec[c] && (issue_bank == BANK_W'(b))),
          .val  (tval_flat[c*TW +: TW]),
          .nz   (bank_nz[c*NBANK + b])
        );
      end
      assign glob_nz[c] = 1'b0;
    end else begin : g_global
      dram_tc_counter #(.W(TW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (issue && start_vec[c]),
        .val  (tval_flat[c*TW +: TW]),
        .nz   (glob_nz[c])
      );
    end
  end

  dram_tc_counter #(.W(ARG_W)) u_sleep (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sleep_load),
    .val  (sleep_len),
    .nz   (sleep_busy)
  );

  always_comb begin
    for (int c = 0; c < NUM_CON; c++) begin
      if (c < NUM_BANKC) busy[c] = bank_nz[c*NBANK + int'(head_bank)];
      else               busy[c] = glob_nz[c];
    end
  end

endmodule

// File: rtl/dram_tc_checker.sv
module dram_tc_checker
  import dram_tc_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int TW    = 8,
  parameter int ARG_W = 8,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CFG_AW = 5,
  localparam int CFG_DW = (TW > NUM_CON) ? TW : NUM_CON
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ARG_W-1:0]  cmd_arg,
  output logic              bus_valid,
  output logic [TYPE_W-1:0] bus_type,
  output logic [BANK_W-1:0] bus_bank,
  output logic [ARG_W-1:0]  bus_arg
);

  logic [NUM_CON-1:0]    head_mask;
  logic [NUM_CON*TW-1:0] tval_flat;
  logic [NUM_CON-1:0]    busy;
  logic                  sleep_busy;
  logic                  fire;
  logic                  is_sleep;

  dram_tc_cfg #(.TW(TW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .sel_type (cmd_type),
    .sel_mask (head_mask),
    .tval_flat(tval_flat)
  );

  assign is_sleep = (cmd_type == CMD_SLP);
  assign fire     = cmd_valid && cmd_ready;

  dram_tc_timers #(.NBANK(NBANK), .TW(TW), .ARG_W(ARG_W)) u_timers (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (fire),
    .issue_bank(cmd_bank),
    .start_vec (start_set(cmd_type)),
    .tval_flat (tval_flat),
    .sleep_load(fire && is_sleep),
    .sleep_len (cmd_arg),
    .head_bank (cmd_bank),
    .busy      (busy),
    .sleep_busy(sleep_busy)
  );

  // only constraints relevant to the head type may hold it back
  assign cmd_ready = ((head_mask & busy) == '0) && !sleep_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_type  <= '0;
      bus_bank  <= '0;
      bus_arg   <= '0;
    end else begin
      bus_valid <= fire && !is_sleep;
      if (fire) begin
        bus_type <= cmd_type;
        bus_bank <= cmd_bank;
        bus_arg  <= cmd_arg;
      end
    end
  end

  // R2: an accepted non-sleep command appears on the bus one cycle later
  a_r2_bus_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_type != CMD_SLP) |=>
      (bus_valid && bus_type == $past(cmd_type) && bus_bank == $past(cmd_bank)));

  // R5: a stalled head leaves the bus empty next cycle
  a_r5_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> !bus_valid);

  // R9: a running sleep window keeps every head out
  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_busy |-> !cmd_ready);

  // R9: an accepted sleep puts nothing on the bus
  a_r9_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_type == CMD_SLP) |=> !bus_valid);

endmodule

// File: tb/dram_tc_checker_tb_top.sv
module dram_tc_checker_tb_top;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0] t;
    logic [2:0] b;
    logic [7:0] a;
    logic [7:0] g;   // expected cycles since previous acceptance, 0 = skip
  } vec_t;

  // types: 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 REF 6 PDN 7 PUP 8 SLP
  // timings: RCD4 RP3 RAS9 RTP3 CCD2 WTR5 CAS4 RFC12 XP2
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd0, 8'd0, 8'd0},   // ACT b0 first
    '{4'd2, 3'd0, 8'd0, 8'd4},   // R6 tRCD
    '{4'd2, 3'd0, 8'd0, 8'd2},   // R6 tCCD expires and reloads same cycle
    '{4'd3, 3'd0, 8'd0, 8'd4},   // R8 read started tCAS, write waits on it
    '{4'd2, 3'd0, 8'd0, 8'd5},   // R8 tWTR
    '{4'd4, 3'd0, 8'd0, 8'd3},   // R6 tRTP
    '{4'd1, 3'd1, 8'd0, 8'd1},   // R7 other bank free
    '{4'd1, 3'd0, 8'd0, 8'd2},   // R7 tRP in bank 0
    '{4'd4, 3'd1, 8'd0, 8'd7},   // R7 tRAS in bank 1
    '{4'd5, 3'd0, 8'd0, 8'd1},   // REF
    '{4'd1, 3'd2, 8'd0, 8'd12},  // R8 tRFC
    '{4'd7, 3'd0, 8'd0, 8'd1},   // PUP, empty mask
    '{4'd2, 3'd2, 8'd0, 8'd3},   // tXP and tRCD
    '{4'd4, 3'd0, 8'd0, 8'd1},   // R4 tCAS running but masked off
    '{4'd8, 3'd0, 8'd6, 8'd1},   // R9 sleep 6
    '{4'd0, 3'd0, 8'd0, 8'd6},   // R9 NOP after sleep
    '{4'd2, 3'd2, 8'd0, 8'd1},   // read, nothing pending
    '{4'd8, 3'd0, 8'd0, 8'd1},   // R9 sleep 0
    '{4'd0, 3'd0, 8'd0, 8'd1},   // R9 blocks nothing
    '{4'd6, 3'd0, 8'd0, 8'd1}    // PDN
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [8:0] cfg_data = '0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [3:0] cmd_type = '0;
  logic [2:0] cmd_bank = '0;
  logic [7:0] cmd_arg = '0;
  logic       bus_valid;
  logic [3:0] bus_type;
  logic [2:0] bus_bank;
  logic [7:0] bus_arg;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  last_acc = 0;
  bit  done = 1'b0;

  dram_tc_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_arg(cmd_arg),
    .bus_valid(bus_valid), .bus_type(bus_type), .bus_bank(bus_bank), .bus_arg(bus_arg)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [8:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present a command, wait for acceptance, return cycles since last acceptance
  task automatic send(input logic [3:0] t, input logic [2:0] b, input logic [7:0] a,
                      output int gap);
    int waits;
    waits = 0;
    cmd_type = t; cmd_bank = b; cmd_arg = a; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready && waits < 1000) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 1000) chk(1'b0, "R5 head never accepted", waits, 0);
    gap = cyc + 1 - last_acc;
    last_acc = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_chk(input logic [3:0] t, input logic [2:0] b, input logic [7:0] a);
    if (t == 4'd8)
      chk(bus_valid == 1'b0, "R9 sleep on bus", int'(bus_valid), 0);
    else
      chk(bus_valid && bus_type == t && bus_bank == b && bus_arg == a,
          "R2 bus content", {bus_valid, bus_type, bus_bank, bus_arg},
          {1'b1, t, b, a});
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int g;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_valid == 1'b0, "R1 bus idle in reset", int'(bus_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd_type = 4'd2; cmd_bank = 3'd0;
    #1;
    chk(bus_valid == 1'b0, "R1 bus idle after reset", int'(bus_valid), 0);
    chk(cmd_ready == 1'b1, "R1 head ready after reset", int'(cmd_ready), 1);

    // R3 timing table then mask table
    cfg_wr(5'd0, 9'd4);  cfg_wr(5'd1, 9'd3);  cfg_wr(5'd2, 9'd9);
    cfg_wr(5'd3, 9'd3);  cfg_wr(5'd4, 9'd2);  cfg_wr(5'd5, 9'd5);
    cfg_wr(5'd6, 9'd4);  cfg_wr(5'd7, 9'd12); cfg_wr(5'd8, 9'd2);
    cfg_wr(5'd17, 9'h182); // ACT: RP RFC XP
    cfg_wr(5'd18, 9'h131); // RD: RCD CCD WTR XP
    cfg_wr(5'd19, 9'h151); // WR: RCD CCD CAS XP
    cfg_wr(5'd20, 9'h10C); // PRE: RAS RTP XP
    cfg_wr(5'd21, 9'h180); // REF: RFC XP
    cfg_wr(5'd22, 9'h080); // PDN: RFC

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].t, VECS[i].b, VECS[i].a, g);
      if (VECS[i].g != 8'd0)
        chk(g == int'(VECS[i].g), "R6 acceptance spacing", g, int'(VECS[i].g));
      bus_chk(VECS[i].t, VECS[i].b, VECS[i].a);
    end

    // R5 stall: read right behind activate in bank 3
    send(4'd1, 3'd3, 8'd0, g);
    cmd_type = 4'd2; cmd_bank = 3'd3; cmd_arg = 8'd0; cmd_valid = 1'b1;
    #1;
    chk(cmd_ready == 1'b0, "R5 ready low while tRCD runs", int'(cmd_ready), 0);
    @(negedge clk); #1;
    chk(cmd_ready == 1'b0 && bus_valid == 1'b0, "R5 stalled head",
        {cmd_ready, bus_valid}, 0);
    send(4'd2, 3'd3, 8'd0, g);
    chk(g == 4, "R7 tRCD per bank", g, 4);
    bus_chk(4'd2, 3'd3, 8'd0);

    // R3 and R4: precharge mask now includes tCAS
    send(4'd2, 3'd2, 8'd0, g);
    chk(g == 2, "R6 tCCD across banks", g, 2);
    cfg_wr(5'd20, 9'h14C);
    send(4'd4, 3'd2, 8'd0, g);
    chk(g == 4, "R4 tCAS relevant after mask write", g, 4);

    // R6 boundary: tCCD of zero
    cfg_wr(5'd4, 9'd0);
    send(4'd1, 3'd4, 8'd0, g);
    cfg_wr(5'd0, 9'd1);
    send(4'd1, 3'd5, 8'd0, g);
    send(4'd2, 3'd5, 8'd0, g);
    send(4'd2, 3'd5, 8'd0, g);
    chk(g == 1, "R6 zero timing allows back-to-back", g, 1);
    bus_chk(4'd2, 3'd5, 8'd0);
    @(negedge clk);
    chk(bus_valid == 1'b0, "R2 no command no bus", int'(bus_valid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule